// File: doc/BRIEF.md
# Port Control and Ready Sequencer

This block is the per-port control word of a storage host port. Software changes it through two write addresses. One sets every bit written as 1. The other clears every bit written as 1. A zero in the write data leaves its bit alone. A read of the set address returns the current status: the held mode bits, the pending command bits, and a ready flag that software polls before it issues commands.

Three bits are commands.

- Port reset holds the port in reset until software clears it.
- Device reset asks the link side to reset the attached device. The bit clears itself when a completion pulse arrives.
- Initialize asks for a port initialization. It also clears itself on its completion pulse.

The remaining bits are modes. Their levels go straight out to neighbouring units. One of them tells the interrupt unit that status bits are cleared by writing one. Ready drops whenever a command starts. It comes back only when the last pending operation completes while port reset is clear.

Top module: `port_ctl_reg`

## Requirements
- R1: After reset, a read of offset 0x0 returns 0x0000_0001: port reset is set, every other bit is 0, and ready_o is 0.
- R2: A write to offset 0x0 sets each writable bit whose data bit is 1, and leaves bits written as 0 unchanged. The writable bits are: 0 port reset, 1 device reset, 2 initialize, 3 write-one-to-clear mode, 5 packet length, 6 resume, 10 32-bit activation, 13 multiplier enable.
- R3: A write to offset 0x4 clears bits 0, 3, 5, 6, 10 and 13 wherever the data bit is 1. It has no effect on bits 1 and 2, nor on bits written as 0.
- R4: A read of offset 0x0 returns the held bits, with ready in bit 31 and all other bits 0. A read of any other offset returns 0.
- R5: Port reset (bit 0) stays set until it is cleared through offset 0x4. ready_o is 0 in every cycle in which it is set.
- R6: Device reset (bit 1) stays set until a dev_rst_done pulse arrives, and clears in the following cycle. A pulse while bit 1 is clear changes nothing.
- R7: Initialize (bit 2) stays set until an init_done pulse arrives, and clears in the following cycle. A pulse while bit 2 is clear changes nothing.
- R8: A write to offset 0x0 with any of bits 0 to 2 set drives ready to 0 in the following cycle.
- R9: Ready rises in the cycle after the last pending device reset or initialize completes, provided port reset was clear at that moment. A completion while port reset is set leaves ready at 0.
- R10: A set write of a command bit in the same cycle as that command's completion pulse restarts the command. The bit stays 1 and ready stays 0.
- R11: The mode outputs follow their bits: woc_mode_o is bit 3, pkt16_o is bit 5 (1 means a 16-byte packet command, 0 means 12-byte), resume_o is bit 6, act32_o is bit 10 and pmul_en_o is bit 13. The request outputs port_rst_o, dev_rst_req_o and init_req_o follow bits 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Byte offset of the access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| dev_rst_done | input | 1 | Pulse: device reset finished |
| init_done | input | 1 | Pulse: port initialize finished |
| port_rst_o | output | 1 | Port held in reset |
| dev_rst_req_o | output | 1 | Device reset pending |
| init_req_o | output | 1 | Initialize pending |
| woc_mode_o | output | 1 | Interrupt status cleared by writing one |
| pkt16_o | output | 1 | 16-byte packet command length |
| resume_o | output | 1 | Resume mode |
| act32_o | output | 1 | 32-bit activation mode |
| pmul_en_o | output | 1 | Port multiplier enable |
| ready_o | output | 1 | Port ready for commands |

## Verification
Two collisions can fall in the same cycle, and both are the dangerous ones.

The first is a completion pulse arriving together with a set write that restarts the same command. The bench provokes it by driving dev_rst_done in the same cycle as a set write of bit 1. It judges that the bit stays 1 and ready stays 0 afterwards, and that a later lone pulse then brings ready back.

The second is a completion that arrives while port reset is still set. The bench provokes it by completing an initialize with port reset set. It judges that ready remains 0 until a fresh operation completes after the clear.

// File: rtl/port_ctl_pkg.sv
// Shared constants for the port control register: bit positions and masks.
// Assumes a 32-bit register with ready in the top bit.
package port_ctl_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 4;

    localparam int B_PRST   = 0;
    localparam int B_DRST   = 1;
    localparam int B_INIT   = 2;
    localparam int B_WOC    = 3;
    localparam int B_PKT16  = 5;
    localparam int B_RESUME = 6;
    localparam int B_ACT32  = 10;
    localparam int B_PMEN   = 13;
    localparam int B_RDY    = DATA_W - 1;

    localparam logic [ADDR_W-1:0] OFS_SET = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_CLR = 4'h4;

    localparam logic [DATA_W-1:0] MODE_MASK =
        (32'd1 << B_WOC) | (32'd1 << B_PKT16) | (32'd1 << B_RESUME) |
        (32'd1 << B_ACT32) | (32'd1 << B_PMEN);
endpackage

// File: rtl/port_ctl_decode.sv
// Address decode: turns a bus access into set, clear and read-select strobes.
// Assumes single-cycle writes and a combinational read path.
module port_ctl_decode
    import port_ctl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic              set_stb,
    output logic              clr_stb,
    output logic              rd_sel
);
    // Strobe generation from the access offset.
    always_comb begin
        rd_sel  = (addr == OFS_SET);
        set_stb = wr && (addr == OFS_SET);
        clr_stb = wr && (addr == OFS_CLR);
    end
endmodule

// File: rtl/port_ctl_modes.sv
// Mode-bit storage: holds the plain mode bits, updated by the set and clear strobes.
// Assumes set and clear never strobe together (distinct offsets).
module port_ctl_modes
    import port_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_stb,
    input  logic              clr_stb,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mode_q
);
    logic [DATA_W-1:0] wsel;

    // Only the mode positions are writable here.
    always_comb wsel = wdata & MODE_MASK;

    // Set and clear update of the mode vector.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (set_stb) mode_q <= mode_q | wsel;
        else if (clr_stb) mode_q <= mode_q & ~wsel;
    end

    // R2: every written mode bit reads 1 afterwards
    a_r2_mode_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> ((mode_q & $past(wsel)) == $past(wsel)));
    // R3: every cleared mode bit reads 0 afterwards
    a_r3_mode_clr: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> ((mode_q & $past(wsel)) == '0));
endmodule

// File: rtl/port_ctl_seq.sv
// Command sequencer: port reset, device reset and initialize bits, plus the ready flag.
// Assumes done pulses are single-cycle; port reset is cleared only by software.
module port_ctl_seq
    import port_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_stb,
    input  logic       clr_stb,
    input  logic [2:0] wcmd,
    input  logic       dev_rst_done,
    input  logic       init_done,
    output logic       prst_q,
    output logic       drst_q,
    output logic       init_q,
    output logic       rdy_q
);
    logic start;
    logic finishing;
    logic remaining;

    // Classify the cycle: command start, op completion, ops still pending.
    always_comb begin
        start     = set_stb && (wcmd != 3'b000);
        finishing = (drst_q && dev_rst_done) || (init_q && init_done);
        remaining = (drst_q && !dev_rst_done) || (init_q && !init_done);
    end

    // Port reset: set by software, cleared only by software.
    always_ff @(posedge clk) begin
        if (!rst_n)                        prst_q <= 1'b1;
        else if (set_stb && wcmd[B_PRST])  prst_q <= 1'b1;
        else if (clr_stb && wcmd[B_PRST])  prst_q <= 1'b0;
    end

    // Device reset: set by software, cleared by its completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)                        drst_q <= 1'b0;
        else if (set_stb && wcmd[B_DRST])  drst_q <= 1'b1;
        else if (dev_rst_done)             drst_q <= 1'b0;
    end

    // Initialize: set by software, cleared by its completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)                        init_q <= 1'b0;
        else if (set_stb && wcmd[B_INIT])  init_q <= 1'b1;
        else if (init_done)                init_q <= 1'b0;
    end

    // Ready: drops on any start, rises when the last op completes outside port reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     rdy_q <= 1'b0;
        else if (start)                                 rdy_q <= 1'b0;
        else if (finishing && !remaining && !prst_q)    rdy_q <= 1'b1;
    end

    // R5: never ready while port reset is held
    a_r5_no_rdy_in_prst: assert property (@(posedge clk) disable iff (!rst_n)
        prst_q |-> !rdy_q);
    // R5: port reset survives any cycle without a clear write of bit 0
    a_r5_prst_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (prst_q && !(clr_stb && wcmd[B_PRST])) |=> prst_q);
    // R6: device reset clears after its completion unless restarted
    a_r6_drst_self_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (drst_q && dev_rst_done && !(set_stb && wcmd[B_DRST])) |=> !drst_q);
    // R7: initialize clears after its completion unless restarted
    a_r7_init_self_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (init_q && init_done && !(set_stb && wcmd[B_INIT])) |=> !init_q);
    // R8: a command start removes ready
    a_r8_rdy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !rdy_q);
    // R9: ready only rises with no command still pending
    a_r9_rdy_rise_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_q) |-> (!drst_q && !init_q && !prst_q));
    // R10: a restart coinciding with completion keeps the command pending
    a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stb && wcmd[B_DRST] && dev_rst_done) |=> (drst_q && !rdy_q));
endmodule

// File: rtl/port_ctl_reg.sv
// Port control register top: set/clear write offsets, status read, command
// sequencing and mode outputs. Assumes one access per cycle on the register bus.
module port_ctl_reg
    import port_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              dev_rst_done,
    input  logic              init_done,
    output logic              port_rst_o,
    output logic              dev_rst_req_o,
    output logic              init_req_o,
    output logic              woc_mode_o,
    output logic              pkt16_o,
    output logic              resume_o,
    output logic              act32_o,
    output logic              pmul_en_o,
    output logic              ready_o
);
    logic              set_stb, clr_stb, rd_sel;
    logic [DATA_W-1:0] mode_q;
    logic              prst_q, drst_q, init_q, rdy_q;
    logic [DATA_W-1:0] status;

    port_ctl_decode u_dec (
        .addr    (reg_addr),
        .wr      (reg_wr),
        .set_stb (set_stb),
        .clr_stb (clr_stb),
        .rd_sel  (rd_sel)
    );

    port_ctl_modes u_modes (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (set_stb),
        .clr_stb (clr_stb),
        .wdata   (reg_wdata),
        .mode_q  (mode_q)
    );

    port_ctl_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_stb      (set_stb),
        .clr_stb      (clr_stb),
        .wcmd         (reg_wdata[2:0]),
        .dev_rst_done (dev_rst_done),
        .init_done    (init_done),
        .prst_q       (prst_q),
        .drst_q       (drst_q),
        .init_q       (init_q),
        .rdy_q        (rdy_q)
    );

    // Assemble the status view of the register.
    always_comb begin
        status         = mode_q;
        status[B_PRST] = prst_q;
        status[B_DRST] = drst_q;
        status[B_INIT] = init_q;
        status[B_RDY]  = rdy_q;
    end

    // Read mux: status at the set offset, zero elsewhere.
    always_comb reg_rdata = rd_sel ? status : '0;

    // Drive the control levels to neighbouring units.
    always_comb begin
        port_rst_o    = prst_q;
        dev_rst_req_o = drst_q;
        init_req_o    = init_q;
        woc_mode_o    = mode_q[B_WOC];
        pkt16_o       = mode_q[B_PKT16];
        resume_o      = mode_q[B_RESUME];
        act32_o       = mode_q[B_ACT32];
        pmul_en_o     = mode_q[B_PMEN];
        ready_o       = rdy_q;
    end

    // R4: other offsets always read zero
    a_r4_other_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != OFS_SET) |-> (reg_rdata == '0));
    // R11: the write-one-to-clear output holds between writes
    a_r11_woc_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_wr) |-> $stable(woc_mode_o));
endmodule

// File: tb/tb_port_ctl_reg.sv
module tb_port_ctl_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dev_rst_done = 1'b0, init_done = 1'b0;
    logic        port_rst_o, dev_rst_req_o, init_req_o, woc_mode_o, pkt16_o;
    logic        resume_o, act32_o, pmul_en_o, ready_o;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    localparam logic [31:0] VALID   = 32'h0000_246F;
    localparam logic [31:0] CLRABLE = 32'h0000_2469;

    logic [31:0] m;   // expected held bits
    logic        rdy; // expected ready

    always #5 clk = ~clk;

    port_ctl_reg dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, reg_rdata, m | ({31'd0, rdy} << 31));
        // R11: outputs follow their bits
        chk("R11", {23'd0, port_rst_o, dev_rst_req_o, init_req_o, woc_mode_o,
                    pkt16_o, resume_o, act32_o, pmul_en_o, ready_o},
            {23'd0, m[0], m[1], m[2], m[3], m[5], m[6], m[10], m[13], rdy});
    endtask

    // One bus cycle plus completion hooks; expected state updated from the requirements.
    task automatic step(input logic [3:0] a, input bit w, input logic [31:0] d,
                        input bit dd, input bit id, input string req);
        logic [31:0] old;
        bit set, clr, start, fin, rem;
        @(negedge clk);
        reg_addr = a; reg_wr = w; reg_wdata = d; dev_rst_done = dd; init_done = id;
        @(posedge clk);
        #2;
        reg_addr = 4'h0; reg_wr = 1'b0; reg_wdata = '0; dev_rst_done = 0; init_done = 0;
        old = m;
        set = w && (a == 4'h0);
        clr = w && (a == 4'h4);
        if (set) m = m | (d & VALID);
        if (clr) m = m & ~(d & CLRABLE);
        if (dd && old[1] && !(set && d[1])) m[1] = 1'b0;
        if (id && old[2] && !(set && d[2])) m[2] = 1'b0;
        start = set && (d[2:0] != 3'b000);
        fin   = (old[1] && dd) || (old[2] && id);
        rem   = (old[1] && !dd) || (old[2] && !id);
        if (start) rdy = 1'b0;
        else if (fin && !rem && !old[0]) rdy = 1'b1;
        #1;
        check_all(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        m = 32'h1; rdy = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1", reg_rdata, 32'h0000_0001);
        check_all("R1");
        // R4: other offsets read zero
        for (int o = 1; o < 16; o++) begin
            @(negedge clk); reg_addr = o[3:0]; #1;
            chk("R4", reg_rdata, 32'h0);
        end
        @(negedge clk); reg_addr = 4'h0;
        // R2: set sweep, one bit at a time
        for (int b = 0; b < 32; b++) step(4'h0, 1, 32'd1 << b, 0, 0, "R2");
        // R3: clear sweep; bits 1 and 2 must survive
        for (int b = 0; b < 32; b++) step(4'h4, 1, 32'd1 << b, 0, 0, "R3");
        chk("R3", reg_rdata & 32'h6, 32'h6);
        // R6 then R9: device done leaves init pending, init done brings ready
        step(4'h0, 0, 0, 1, 0, "R6");
        step(4'h0, 0, 0, 0, 1, "R9");
        chk("R9", {31'd0, ready_o}, 32'd1);
        // R8: device reset start drops ready
        step(4'h0, 1, 32'h2, 0, 0, "R8");
        step(4'h0, 0, 0, 0, 1, "R7");   // init pulse while idle is ignored
        step(4'h0, 0, 0, 1, 0, "R9");
        step(4'h0, 0, 0, 1, 0, "R6");   // device pulse while idle is ignored
        // R5: port reset drops ready and blocks it
        step(4'h0, 1, 32'h1, 0, 0, "R5");
        step(4'h0, 1, 32'h4, 0, 0, "R8");
        step(4'h0, 0, 0, 0, 1, "R9");
        chk("R9", {31'd0, ready_o}, 32'd0);
        step(4'h4, 1, 32'h1, 0, 0, "R5");
        // R10: restart coincides with completion
        step(4'h0, 1, 32'h2, 0, 0, "R8");
        step(4'h0, 1, 32'h2, 1, 0, "R10");
        chk("R10", {30'd0, dev_rst_req_o, ready_o}, 32'd2);
        step(4'h0, 0, 0, 1, 0, "R10");
        // R3: clear write cannot cancel a pending command
        step(4'h0, 1, 32'h4, 0, 0, "R8");
        step(4'h4, 1, 32'h6, 0, 0, "R3");
        step(4'h0, 0, 0, 0, 1, "R7");
        // both completing in one cycle
        step(4'h0, 1, 32'h6, 0, 0, "R8");
        step(4'h0, 0, 0, 1, 1, "R9");
        // R2/R3: all ones
        step(4'h0, 1, 32'hFFFF_FFF8, 0, 0, "R2");
        step(4'h4, 1, 32'hFFFF_FFFE, 0, 0, "R3");
        step(4'h8, 1, 32'hFFFF_FFFF, 0, 0, "R4");
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule